// File: doc/BRIEF.md
# Serial-in, parallel-out word FIFO

This block receives a serial bit stream and turns it into parallel words for a reader. A slow serial clock and a data line come in from outside. The block synchronises both to the system clock and samples one data bit on each rising edge of the serial clock. Bits fill the word from bit 0 upward. After 8 or 9 bits, as chosen by a width-select input, the word is complete and goes into an internal memory whose depth is a parameter. If the memory is full at that moment, the word is dropped.

A reader takes words out in arrival order with an active-low read strobe. The block synchronises the strobe and treats each falling edge as one read request. The request is ignored when the memory is empty. The word read stays on the data outputs. A separate drive-enable output marks when the bus would be driven: only while the strobe is held low and the active-low output enable is also low. This supports two styles of reading. The reader can pulse the strobe once per word, or hold the strobe low and gate the bus with the output enable.

The block has level flags for empty, almost empty, half full and full. It also gives a one-cycle pulse each time a word is completed. Reset empties the memory and throws away any partly assembled word.

Top module: `sipo_fifo`

## Requirements
- R1: On each synchronised rising edge of `ser_clk`, the block samples `ser_din` into the next bit of the word being assembled. The first bit of a word lands on `q_data[0]`, the second on `q_data[1]`, and so on.
- R2: With `wide9` = 1, a word is 9 bits long. With `wide9` = 0, a word is 8 bits long and its stored bit 8 is always 0.
- R3: A word completed while `full` is 1 is discarded. The occupancy does not change, and the stored words and their order are not affected.
- R4: A falling edge of `rd_n` while `empty` is 0 removes the oldest stored word and places it on `q_data`. Words leave in the order they were completed.
- R5: A falling edge of `rd_n` while `empty` is 1 leaves `q_data` unchanged, and `empty` stays 1.
- R6: `q_en` is 1 only when the synchronised `rd_n` is low and `oe_n` is low. In every other case `q_en` is 0, including whenever `rd_n` is high, whatever the value of `oe_n`.
- R7: With occupancy N, the flags are as follows. `empty` = (N == 0). `almost_empty` = (N <= AE_LEVEL). `half_full` = (N >= DEPTH/2). `full` = (N == DEPTH).
- R8: Reset empties the memory and sets `empty` and `almost_empty`. It clears `half_full`, `full` and `q_data`. It discards a partly assembled word, so the next serial bit after reset lands on bit 0.
- R9: `word_done` pulses high for exactly one clock cycle for each completed word, whether the word is stored or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_din | input | 1 | Serial data bit |
| wide9 | input | 1 | Word width select: 1 for 9 bits, 0 for 8 bits; hold static |
| rd_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output enable |
| q_data | output | 9 | Last word read |
| q_en | output | 1 | Bus drive enable for q_data |
| word_done | output | 1 | One-cycle pulse when a word is completed |
| empty | output | 1 | Occupancy is zero |
| almost_empty | output | 1 | Occupancy is at or below AE_LEVEL |
| half_full | output | 1 | Occupancy is at or above DEPTH/2 |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
The assertions check on every cycle these behaviours:
- The occupancy never exceeds the depth.
- A word completed while full leaves the occupancy unchanged.
- A read while empty leaves the output unchanged.
- The bit counter advances by one per serial edge.
- `full` implies `half_full`.
- `word_done` never lasts longer than one cycle.

Only the bench scenarios can show the following. Bits arrive least significant first. Words come out in order across mixed widths. Bit 8 is zeroed in 8-bit mode. The flag thresholds change as the memory fills. A dropped word really is absent when the memory is drained. A partial word is lost on reset.

// File: rtl/sipo_fifo.sv
module sipo_fifo #(
  parameter int DEPTH    = 16,
  parameter int AE_LEVEL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       wide9,
  input  logic       rd_n,
  input  logic       oe_n,
  output logic [8:0] q_data,
  output logic       q_en,
  output logic       word_done,
  output logic       empty,
  output logic       almost_empty,
  output logic       half_full,
  output logic       full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [2:0]    sck_q;
  logic [1:0]    sd_q;
  logic [2:0]    rd_q;
  logic [3:0]    bitcnt;
  logic [8:0]    shreg;
  logic [8:0]    asm_next;
  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire       sck_rise  = sck_q[1] & ~sck_q[2];
  wire       din_s     = sd_q[1];
  wire       rd_fall   = rd_q[2] & ~rd_q[1];
  wire       rd_low    = ~rd_q[1];
  wire [3:0] last_idx  = wide9 ? 4'd8 : 4'd7;
  wire       word_last = sck_rise && (bitcnt == last_idx);
  wire       push      = word_last && !full;
  wire       pop       = rd_fall && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0;
      sd_q  <= '0;
      rd_q  <= '1;
    end else begin
      sck_q <= {sck_q[1:0], ser_clk};
      sd_q  <= {sd_q[0], ser_din};
      rd_q  <= {rd_q[1:0], rd_n};
    end
  end

  always_comb begin
    asm_next = shreg;
    asm_next[bitcnt] = din_s;
    if (!wide9) asm_next[8] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      shreg     <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= word_last;
      if (sck_rise) begin
        if (word_last) begin
          bitcnt <= '0;
          shreg  <= '0;
        end else begin
          bitcnt <= bitcnt + 4'd1;
          shreg  <= asm_next;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= asm_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      q_data <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop) begin
        q_data <= mem[rd_ptr];
        rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty        = (count == '0);
  assign almost_empty = (count <= CW'(AE_LEVEL));
  assign half_full    = (count >= CW'(HALF));
  assign full         = (count == CW'(DEPTH));
  assign q_en         = rd_low & ~oe_n;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R7
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (word_last && full && !rd_fall) |=> $stable(count)); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_fall && empty && !word_last) |=> ($stable(q_data) && empty)); // R5
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (sck_rise && !word_last) |=> (bitcnt == $past(bitcnt) + 4'd1)); // R1
  AST_FULL_HALF: assert property (@(posedge clk) disable iff (!rst_n) full |-> (half_full && !empty)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) word_done |=> !word_done); // R9
endmodule

// File: tb/sipo_fifo_bench.sv
module sipo_fifo_bench;
  localparam int DEPTH = 8;
  localparam int AEL   = 2;

  logic clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic wide9 = 1'b1, rd_n = 1'b1, oe_n = 1'b1;
  logic [8:0] q_data;
  logic q_en, word_done, empty, almost_empty, half_full, full;
  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sipo_fifo #(.DEPTH(DEPTH), .AE_LEVEL(AEL)) u_sipo_fifo (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .wide9(wide9),
    .rd_n(rd_n), .oe_n(oe_n), .q_data(q_data), .q_en(q_en), .word_done(word_done),
    .empty(empty), .almost_empty(almost_empty), .half_full(half_full), .full(full));

  always @(negedge clk) if (rst_n && word_done) done_cnt++;

  localparam logic [9:0] VEC [6] = '{10'h1A5, 10'h0C3, 10'h300, 10'h0FF, 10'h201, 10'h15A};

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(logic [8:0] w, int n);
    for (int i = 0; i < n; i++) begin
      ser_din = w[i];
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic read_word(output logic [8:0] w);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    w = q_data;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic flags(string tag, logic [3:0] exp);
    check(tag, {12'd0, empty, almost_empty, half_full, full}, {12'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] got;
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    flags("R8 reset flags", 4'b1100);
    check("R8 reset q_data", {7'd0, q_data}, 16'd0);

    foreach (VEC[k]) begin
      wide9 = VEC[k][9];
      d0 = done_cnt;
      send_bits(VEC[k][8:0], wide9 ? 9 : 8);
      check("R9 one pulse per word", 16'(done_cnt - d0), 16'd1);
      read_word(got);
      check(wide9 ? "R1 R2 R4 word 9b" : "R1 R2 R4 word 8b bit8 zero",
            {7'd0, got}, {7'd0, wide9 ? VEC[k][8:0] : {1'b0, VEC[k][7:0]}});
    end

    wide9 = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      send_bits(9'(9'h101 + i * 37), 9);
      if (i == 1) flags("R7 two words", 4'b0100);
      if (i == 2) flags("R7 three words", 4'b0000);
      if (i == 3) flags("R7 four words half", 4'b0010);
      if (i == 6) flags("R7 seven words", 4'b0010);
    end
    flags("R7 full", 4'b0011);
    d0 = done_cnt;
    send_bits(9'h0AA, 9);
    check("R9 dropped word pulses", 16'(done_cnt - d0), 16'd1);
    flags("R3 still full after drop", 4'b0011);
    for (int i = 0; i < DEPTH; i++) begin
      read_word(got);
      check("R3 R4 drain order", {7'd0, got}, {7'd0, 9'(9'h101 + i * 37)});
    end
    flags("R3 drained empty", 4'b1100);

    read_word(got);
    check("R5 empty read keeps data", {7'd0, got}, {7'd0, 9'(9'h101 + (DEPTH - 1) * 37)});
    flags("R5 still empty", 4'b1100);

    send_bits(9'h133, 9);
    rd_n = 1'b0; oe_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 rd low oe high", {15'd0, q_en}, 16'd0);
    oe_n = 1'b0;
    @(negedge clk);
    check("R6 rd low oe low", {15'd0, q_en}, 16'd1);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 rd high oe low", {15'd0, q_en}, 16'd0);
    oe_n = 1'b1;
    @(negedge clk);
    check("R6 rd high oe high", {15'd0, q_en}, 16'd0);
    check("R4 hold-low read data", {7'd0, q_data}, 16'h0133);

    send_bits(9'h1FF, 3);
    send_bits(9'h1FF, 9);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    flags("R8 reset after fill", 4'b1100);
    send_bits(9'h0F0, 3);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_bits(9'h14B, 9);
    read_word(got);
    check("R8 partial word discarded", {7'd0, got}, 16'h014B);
    flags("R8 empty after read", 4'b1100);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule